// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions in program order between issue and retirement. An issue stage claims one slot per cycle and receives the slot index as the tag of the instruction's result. Execution units later broadcast a value together with that tag. The block captures the value into the matching slot and marks it finished. Instructions that issue later can read a finished but not yet retired value by tag on a set of lookup ports, so they do not have to wait for the register file.

The oldest slot retires once its result is present. An arithmetic result goes to an architectural register write port and a store goes to a store-commit port. A branch retires silently. When a branch turns out to be mispredicted, every slot younger than it is discarded in one cycle, and the next allocation lands directly after the branch. A fault is recorded in its slot at completion time. It is reported only when that slot becomes the oldest, and all younger work is then discarded. This keeps faults precise.

The flush tag must name a live branch slot. Completion tags must come from an allocation that has not yet retired.

Top module: `spec_rob`

## Requirements
- R1: `alloc_ready` is high exactly when fewer than DEPTH slots are live, `flush_valid` is low and no fault is retiring this cycle. `alloc_tag` always shows the next free slot, and tags advance by one modulo DEPTH per accepted allocation.
- R2: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, and no retire, store or fault output is active. After DEPTH allocations without retirement `alloc_ready` is 0.
- R3: A completion whose tag names a live slot stores `cmpl_value` and `cmpl_exc` there and marks it finished from the next cycle. A completion naming a free slot changes nothing.
- R4: Only the oldest live slot retires, only when it is finished, at most one per cycle and in allocation order.
- R5: The kind code is 0 for an arithmetic result, 1 for a store and 2 for a branch. A retiring kind 0 drives `reg_wr_en` with `reg_wr_idx`=destination and `reg_wr_data`=value. A retiring kind 1 drives `st_en` with `st_addr`=destination and `st_data`=value. A retiring kind 2 drives neither. The two ports are never active together.
- R6: Lookup port k reports ready with the slot's value when `src_tag` slice k names a live, finished slot, and not ready otherwise. A value written at an edge is visible after that edge.
- R7: A flush naming branch tag B discards every slot younger than B, and the next `alloc_tag` becomes B+1 modulo DEPTH. B and older slots stay and retire normally.
- R8: A completion arriving in the same cycle as a flush that discards its target slot is dropped. When that slot is reallocated, it is not finished.
- R9: A slot completed with the fault flag raises `exc_raise` with `exc_tag` when it is the oldest finished slot. It writes neither port, and the buffer is empty after that cycle.
- R10: An allocation and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | Kind code of the issuing instruction (0 arith, 1 store, 2 branch) |
| alloc_dest | input | DEST_W | Destination register number or store address |
| alloc_ready | output | 1 | A request this cycle is accepted |
| alloc_tag | output | TAG_W | Slot the next accepted request takes |
| cmpl_valid | input | 1 | Result broadcast present |
| cmpl_tag | input | TAG_W | Slot the broadcast targets |
| cmpl_value | input | DATA_W | Broadcast result value |
| cmpl_exc | input | 1 | Broadcast carries a fault |
| flush_valid | input | 1 | Mispredicted branch recovery |
| flush_tag | input | TAG_W | Tag of the mispredicted branch |
| src_tag | input | NSRC*TAG_W | Lookup tags, port k in slice k |
| src_ready | output | NSRC | Lookup hit on a finished live slot |
| src_value | output | NSRC*DATA_W | Lookup values, port k in slice k |
| reg_wr_en | output | 1 | Architectural register write |
| reg_wr_idx | output | DEST_W | Register number written |
| reg_wr_data | output | DATA_W | Register value written |
| st_en | output | 1 | Store commit |
| st_addr | output | DEST_W | Store address |
| st_data | output | DATA_W | Store data |
| exc_raise | output | 1 | Precise fault reported |
| exc_tag | output | TAG_W | Slot of the faulting instruction |

## Verification
The in-line properties check several rules on every cycle. The occupancy never exceeds the depth. Nothing retires from an empty buffer. The register and store ports are never active together and stay quiet when a fault is reported. The next free slot follows a flushed branch or a faulting slot. Any accepted completion leaves its slot finished, and any new allocation leaves its slot unfinished. Whether the lookup ports, the retire stream and the flush-versus-broadcast race carry the right values over a whole instruction history can only be shown by the bench. Its queue model replays directed cases for each of these and a long random mix of allocations, completions, flushes and faults, and it compares every output on every clock.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      K_ARITH  = 2'd0,
      K_STORE  = 2'd1,
      K_BRANCH = 2'd2
   } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter  int DEPTH = 16,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int PTR_W = TAG_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req_i,
   input  logic             flush_i,
   input  logic [TAG_W-1:0] flush_tag_i,
   input  logic             retire_i,
   input  logic             exc_i,
   output logic             alloc_ok_o,
   output logic             alloc_fire_o,
   output logic [TAG_W-1:0] head_idx_o,
   output logic [TAG_W-1:0] tail_idx_o,
   output logic [DEPTH-1:0] live_o,
   output logic [DEPTH-1:0] kill_o
);
   logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d, count;
   logic [TAG_W-1:0] flush_off;
   logic             full;

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("rob_ptr_ctrl: DEPTH must be a power of two of at least 2");
   end

   assign count      = tail_q - head_q;
   assign full       = (count == PTR_W'(DEPTH));
   assign flush_off  = flush_tag_i - head_q[TAG_W-1:0];
   assign head_idx_o = head_q[TAG_W-1:0];
   assign tail_idx_o = tail_q[TAG_W-1:0];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [TAG_W-1:0] age;
      assign age       = TAG_W'(i) - head_q[TAG_W-1:0];
      assign live_o[i] = ({1'b0, age} < count);
      assign kill_o[i] = flush_i && live_o[i] && (age > flush_off);
   end

   assign alloc_ok_o   = !full && !flush_i && !exc_i;
   assign alloc_fire_o = alloc_req_i && alloc_ok_o;

   always_comb begin
      head_d = head_q;
      tail_d = tail_q;
      if (exc_i) begin
         head_d = head_q + PTR_W'(1);
         tail_d = head_q + PTR_W'(1);
      end else begin
         if (retire_i)
            head_d = head_q + PTR_W'(1);
         if (flush_i)
            tail_d = head_q + {1'b0, flush_off} + PTR_W'(1);
         else if (alloc_fire_o)
            tail_d = tail_q + PTR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_d;
         tail_q <= tail_d;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PTR_W'(DEPTH)); // R2
   AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !retire_i); // R4
   AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !exc_i) |=> tail_q[TAG_W-1:0] == TAG_W'($past(flush_tag_i) + TAG_W'(1))); // R7
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
   parameter  int DEPTH  = 16,
   parameter  int DATA_W = 32,
   parameter  int DEST_W = 16,
   parameter  int NSRC   = 2,
   localparam int TAG_W  = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc_we_i,
   input  logic [TAG_W-1:0]       alloc_idx_i,
   input  logic [1:0]             alloc_kind_i,
   input  logic [DEST_W-1:0]      alloc_dest_i,
   input  logic                   cmpl_we_i,
   input  logic [TAG_W-1:0]       cmpl_idx_i,
   input  logic [DATA_W-1:0]      cmpl_value_i,
   input  logic                   cmpl_exc_i,
   input  logic [TAG_W-1:0]       head_idx_i,
   output logic [1:0]             head_kind_o,
   output logic [DEST_W-1:0]      head_dest_o,
   output logic [DATA_W-1:0]      head_value_o,
   output logic                   head_done_o,
   output logic                   head_exc_o,
   input  logic [NSRC*TAG_W-1:0]  src_idx_i,
   output logic [NSRC-1:0]        src_done_o,
   output logic [NSRC*DATA_W-1:0] src_value_o
);
   logic [1:0]        kind_q  [DEPTH];
   logic [DEST_W-1:0] dest_q  [DEPTH];
   logic [DATA_W-1:0] value_q [DEPTH];
   logic [DEPTH-1:0]  done_q;
   logic [DEPTH-1:0]  exc_q;

   initial begin
      if (NSRC < 1 || DATA_W < 1 || DEST_W < 1)
         $error("rob_entry_store: NSRC, DATA_W and DEST_W must be positive");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            kind_q[i]  <= '0;
            dest_q[i]  <= '0;
            value_q[i] <= '0;
            done_q[i]  <= 1'b0;
            exc_q[i]   <= 1'b0;
         end else if (alloc_we_i && alloc_idx_i == TAG_W'(i)) begin
            kind_q[i] <= alloc_kind_i;
            dest_q[i] <= alloc_dest_i;
            done_q[i] <= 1'b0;
            exc_q[i]  <= 1'b0;
         end else if (cmpl_we_i && cmpl_idx_i == TAG_W'(i)) begin
            value_q[i] <= cmpl_value_i;
            done_q[i]  <= 1'b1;
            exc_q[i]   <= cmpl_exc_i;
         end
      end
   end

   assign head_kind_o  = kind_q[head_idx_i];
   assign head_dest_o  = dest_q[head_idx_i];
   assign head_value_o = value_q[head_idx_i];
   assign head_done_o  = done_q[head_idx_i];
   assign head_exc_o   = exc_q[head_idx_i];

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic [TAG_W-1:0] idx;
      assign idx                           = src_idx_i[k*TAG_W +: TAG_W];
      assign src_done_o[k]                 = done_q[idx];
      assign src_value_o[k*DATA_W +: DATA_W] = value_q[idx];
   end

   AST_ALLOC_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_we_i |=> !done_q[$past(alloc_idx_i)]); // R3
   AST_CMPL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_we_i |=> done_q[$past(cmpl_idx_i)]); // R3
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
   parameter  int DEPTH  = 16,
   parameter  int DATA_W = 32,
   parameter  int DEST_W = 16,
   localparam int TAG_W  = $clog2(DEPTH)
) (
   input  logic              head_live_i,
   input  logic              head_done_i,
   input  logic              head_exc_i,
   input  logic [1:0]        head_kind_i,
   input  logic [DEST_W-1:0] head_dest_i,
   input  logic [DATA_W-1:0] head_value_i,
   input  logic [TAG_W-1:0]  head_idx_i,
   output logic              retire_o,
   output logic              exc_o,
   output logic              reg_wr_en_o,
   output logic [DEST_W-1:0] reg_wr_idx_o,
   output logic [DATA_W-1:0] reg_wr_data_o,
   output logic              st_en_o,
   output logic [DEST_W-1:0] st_addr_o,
   output logic [DATA_W-1:0] st_data_o,
   output logic [TAG_W-1:0]  exc_tag_o
);
   import rob_pkg::*;

   assign retire_o      = head_live_i && head_done_i;
   assign exc_o         = retire_o && head_exc_i;
   assign reg_wr_en_o   = retire_o && !head_exc_i && (head_kind_i == K_ARITH);
   assign st_en_o       = retire_o && !head_exc_i && (head_kind_i == K_STORE);
   assign reg_wr_idx_o  = head_dest_i;
   assign reg_wr_data_o = head_value_i;
   assign st_addr_o     = head_dest_i;
   assign st_data_o     = head_value_i;
   assign exc_tag_o     = head_idx_i;
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
   parameter  int DEPTH  = 16,
   parameter  int DATA_W = 32,
   parameter  int DEST_W = 16,
   parameter  int NSRC   = 2,
   localparam int TAG_W  = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alloc_valid,
   input  logic [1:0]             alloc_kind,
   input  logic [DEST_W-1:0]      alloc_dest,
   output logic                   alloc_ready,
   output logic [TAG_W-1:0]       alloc_tag,
   input  logic                   cmpl_valid,
   input  logic [TAG_W-1:0]       cmpl_tag,
   input  logic [DATA_W-1:0]      cmpl_value,
   input  logic                   cmpl_exc,
   input  logic                   flush_valid,
   input  logic [TAG_W-1:0]       flush_tag,
   input  logic [NSRC*TAG_W-1:0]  src_tag,
   output logic [NSRC-1:0]        src_ready,
   output logic [NSRC*DATA_W-1:0] src_value,
   output logic                   reg_wr_en,
   output logic [DEST_W-1:0]      reg_wr_idx,
   output logic [DATA_W-1:0]      reg_wr_data,
   output logic                   st_en,
   output logic [DEST_W-1:0]      st_addr,
   output logic [DATA_W-1:0]      st_data,
   output logic                   exc_raise,
   output logic [TAG_W-1:0]       exc_tag
);
   logic             alloc_fire, retire_go, exc_go, cmpl_we;
   logic [TAG_W-1:0] head_idx;
   logic [DEPTH-1:0] live, kill;
   logic [1:0]       head_kind;
   logic [DEST_W-1:0] head_dest;
   logic [DATA_W-1:0] head_value;
   logic             head_done, head_exc;
   logic [NSRC-1:0]  src_done;

   rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_req_i  (alloc_valid),
      .flush_i      (flush_valid),
      .flush_tag_i  (flush_tag),
      .retire_i     (retire_go),
      .exc_i        (exc_go),
      .alloc_ok_o   (alloc_ready),
      .alloc_fire_o (alloc_fire),
      .head_idx_o   (head_idx),
      .tail_idx_o   (alloc_tag),
      .live_o       (live),
      .kill_o       (kill)
   );

   // a broadcast lands only on a live slot that survives this cycle
   assign cmpl_we = cmpl_valid && live[cmpl_tag] && !kill[cmpl_tag] && !exc_go;

   rob_entry_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .NSRC(NSRC)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_we_i   (alloc_fire),
      .alloc_idx_i  (alloc_tag),
      .alloc_kind_i (alloc_kind),
      .alloc_dest_i (alloc_dest),
      .cmpl_we_i    (cmpl_we),
      .cmpl_idx_i   (cmpl_tag),
      .cmpl_value_i (cmpl_value),
      .cmpl_exc_i   (cmpl_exc),
      .head_idx_i   (head_idx),
      .head_kind_o  (head_kind),
      .head_dest_o  (head_dest),
      .head_value_o (head_value),
      .head_done_o  (head_done),
      .head_exc_o   (head_exc),
      .src_idx_i    (src_tag),
      .src_done_o   (src_done),
      .src_value_o  (src_value)
   );

   for (genvar k = 0; k < NSRC; k++) begin : g_fwd
      assign src_ready[k] = src_done[k] && live[src_tag[k*TAG_W +: TAG_W]];
   end

   rob_retire #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_ret (
      .head_live_i   (live[head_idx]),
      .head_done_i   (head_done),
      .head_exc_i    (head_exc),
      .head_kind_i   (head_kind),
      .head_dest_i   (head_dest),
      .head_value_i  (head_value),
      .head_idx_i    (head_idx),
      .retire_o      (retire_go),
      .exc_o         (exc_go),
      .reg_wr_en_o   (reg_wr_en),
      .reg_wr_idx_o  (reg_wr_idx),
      .reg_wr_data_o (reg_wr_data),
      .st_en_o       (st_en),
      .st_addr_o     (st_addr),
      .st_data_o     (st_data),
      .exc_tag_o     (exc_tag)
   );

   assign exc_raise = exc_go;

   AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && st_en)); // R5
   AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_raise |-> (!reg_wr_en && !st_en)); // R9
   AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      exc_raise |=> (alloc_tag == TAG_W'($past(exc_tag) + TAG_W'(1))) && !reg_wr_en && !st_en); // R9
endmodule

// File: tb/spec_rob_bench.sv
`timescale 1ns/1ps
module spec_rob_bench;
   localparam int D  = 16;
   localparam int TW = 4;
   localparam int DW = 32;
   localparam int EW = 16;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          alloc_valid;
   logic [1:0]    alloc_kind;
   logic [EW-1:0] alloc_dest;
   logic          alloc_ready;
   logic [TW-1:0] alloc_tag;
   logic          cmpl_valid;
   logic [TW-1:0] cmpl_tag;
   logic [DW-1:0] cmpl_value;
   logic          cmpl_exc;
   logic          flush_valid;
   logic [TW-1:0] flush_tag;
   logic [NS*TW-1:0] src_tag;
   logic [NS-1:0] src_ready;
   logic [NS*DW-1:0] src_value;
   logic          reg_wr_en, st_en, exc_raise;
   logic [EW-1:0] reg_wr_idx, st_addr;
   logic [DW-1:0] reg_wr_data, st_data;
   logic [TW-1:0] exc_tag;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int            m_head, m_cnt;
   int            m_kind [D];
   logic [EW-1:0] m_dest [D];
   logic [DW-1:0] m_val  [D];
   bit            m_done [D];
   bit            m_exc  [D];

   always #2.5 clk = ~clk;

   spec_rob #(.DEPTH(D), .DATA_W(DW), .DEST_W(EW), .NSRC(NS)) u_spec_rob (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value), .cmpl_exc(cmpl_exc),
      .flush_valid(flush_valid), .flush_tag(flush_tag),
      .src_tag(src_tag), .src_ready(src_ready), .src_value(src_value),
      .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
      .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
      .exc_raise(exc_raise), .exc_tag(exc_tag)
   );

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int age(int t);
      return (t - m_head + D) % D;
   endfunction

   function automatic bit m_live(int t);
      return age(t) < m_cnt;
   endfunction

   task automatic clear_inputs();
      alloc_valid = 0; alloc_kind = 0; alloc_dest = 0;
      cmpl_valid = 0; cmpl_tag = 0; cmpl_value = 0; cmpl_exc = 0;
      flush_valid = 0; flush_tag = 0;
   endtask

   task automatic compare();
      bit ex, ret;
      ex  = m_cnt > 0 && m_done[m_head] && m_exc[m_head];
      ret = m_cnt > 0 && m_done[m_head];
      chk("R1 alloc_ready", alloc_ready, (m_cnt < D) && !flush_valid && !ex);
      chk("R1 alloc_tag", alloc_tag, (m_head + m_cnt) % D);
      chk("R4 reg_wr_en", reg_wr_en, ret && !m_exc[m_head] && m_kind[m_head] == 0);
      chk("R5 st_en", st_en, ret && !m_exc[m_head] && m_kind[m_head] == 1);
      if (reg_wr_en) begin
         chk("R5 reg_wr_idx", reg_wr_idx, m_dest[m_head]);
         chk("R5 reg_wr_data", reg_wr_data, m_val[m_head]);
      end
      if (st_en) begin
         chk("R5 st_addr", st_addr, m_dest[m_head]);
         chk("R5 st_data", st_data, m_val[m_head]);
      end
      chk("R9 exc_raise", exc_raise, ex);
      if (ex) chk("R9 exc_tag", exc_tag, m_head);
      for (int k = 0; k < NS; k++) begin
         int t;
         bit e;
         t = src_tag[k*TW +: TW];
         e = m_live(t) && m_done[t];
         chk("R6 src_ready", src_ready[k], e);
         if (e) chk("R6 src_value", src_value[k*DW +: DW], m_val[t]);
      end
   endtask

   task automatic model_step();
      bit ex, ret, aok;
      int fd, tail, ncnt;
      ex   = m_cnt > 0 && m_done[m_head] && m_exc[m_head];
      ret  = m_cnt > 0 && m_done[m_head];
      aok  = (m_cnt < D) && !flush_valid && !ex;
      fd   = age(flush_tag);
      tail = (m_head + m_cnt) % D;
      if (cmpl_valid && m_live(cmpl_tag) && !ex && !(flush_valid && age(cmpl_tag) > fd)) begin
         m_val[cmpl_tag]  = cmpl_value;
         m_done[cmpl_tag] = 1;
         m_exc[cmpl_tag]  = cmpl_exc;
      end
      if (alloc_valid && aok) begin
         m_kind[tail] = alloc_kind;
         m_dest[tail] = alloc_dest;
         m_done[tail] = 0;
         m_exc[tail]  = 0;
      end
      if (ex) begin
         m_head = (m_head + 1) % D;
         m_cnt  = 0;
      end else begin
         ncnt = m_cnt;
         if (flush_valid) ncnt = fd + 1;
         else if (alloc_valid && aok) ncnt = m_cnt + 1;
         if (ret) begin
            m_head = (m_head + 1) % D;
            ncnt--;
         end
         m_cnt = ncnt;
      end
   endtask

   // called at a falling edge with the inputs for this cycle applied
   task automatic tick();
      #1;
      compare();
      @(posedge clk);
      #1;
      model_step();
      clear_inputs();
      @(negedge clk);
   endtask

   task automatic put_alloc(int kind, int dest);
      alloc_valid = 1; alloc_kind = 2'(kind); alloc_dest = EW'(dest);
   endtask

   task automatic put_cmpl(int tag, logic [DW-1:0] v, bit e);
      cmpl_valid = 1; cmpl_tag = TW'(tag); cmpl_value = v; cmpl_exc = e;
   endtask

   task automatic look(int t0, int t1);
      src_tag = {TW'(t1), TW'(t0)};
      #1;
   endtask

   task automatic random_stim(int cyc);
      clear_inputs();
      src_tag = NS*TW'($urandom);
      if ($urandom % 4 != 0) put_alloc($urandom % 3, $urandom);
      if ((cyc % 200) > 40 && $urandom % 2 == 0) begin
         int t;
         if (m_cnt > 0 && $urandom % 4 != 0) t = (m_head + ($urandom % m_cnt)) % D;
         else t = $urandom % D;
         put_cmpl(t, $urandom, ($urandom % 50) == 0);
      end
      if (m_cnt > 0 && $urandom % 12 == 0) begin
         int s;
         s = $urandom % m_cnt;
         for (int i = 0; i < m_cnt; i++) begin
            int t;
            t = (m_head + (s + i) % m_cnt) % D;
            if (!flush_valid && m_kind[t] == 2) begin
               flush_valid = 1;
               flush_tag = TW'(t);
            end
         end
      end
   endtask

   initial begin
      int base, b2;
      rst_n = 0;
      clear_inputs();
      src_tag = '0;
      m_head = 0; m_cnt = 0;
      for (int i = 0; i < D; i++) begin
         m_kind[i] = 0; m_dest[i] = 0; m_val[i] = 0; m_done[i] = 0; m_exc[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R2 reset alloc_ready", alloc_ready, 1);
      chk("R2 reset alloc_tag", alloc_tag, 0);
      chk("R2 reset reg_wr_en", reg_wr_en, 0);
      chk("R2 reset st_en", st_en, 0);
      chk("R2 reset exc_raise", exc_raise, 0);

      // fill without completions
      for (int i = 0; i < D; i++) begin
         put_alloc(i % 2, 100 + i);
         tick();
      end
      chk("R2 full alloc_ready", alloc_ready, 0);

      // forwarding of a finished, unretired slot
      put_cmpl(5, 32'h55, 0);
      tick();
      look(5, 6);
      chk("R3 done after completion", src_ready[0], 1);
      chk("R3 captured value", src_value[DW-1:0], 32'h55);
      chk("R6 unfinished not ready", src_ready[1], 0);
      chk("R4 no retire past unfinished head", reg_wr_en | st_en, 0);

      // drain in reverse completion order
      for (int i = D - 1; i >= 0; i--) begin
         put_cmpl(i, 32'h1000 + i, 0);
         tick();
      end
      repeat (D + 2) tick();
      chk("R4 drained", alloc_tag, 0);

      // flush racing with a broadcast to a younger slot
      base = (m_head + m_cnt) % D;
      put_alloc(0, 1); tick();
      put_alloc(2, 2); tick();
      put_alloc(0, 3); tick();
      put_alloc(1, 4); tick();
      flush_valid = 1; flush_tag = TW'((base + 1) % D);
      put_cmpl((base + 2) % D, 32'h77, 0);
      tick();
      chk("R7 tail after branch", alloc_tag, (base + 2) % D);
      look((base + 2) % D, (base + 3) % D);
      chk("R8 racing broadcast dropped", src_ready[0], 0);
      chk("R7 younger slot gone", src_ready[1], 0);
      put_alloc(0, 9); tick();
      look((base + 2) % D, base);
      chk("R8 reallocated slot unfinished", src_ready[0], 0);
      put_cmpl(base, 32'hA1, 0); tick();
      chk("R7 older slot retires", reg_wr_en, 1);
      chk("R7 older slot value", reg_wr_data, 32'hA1);
      put_alloc(0, 10);
      put_cmpl((base + 1) % D, 32'hB2, 0);
      tick();
      chk("R10 alloc with retire", alloc_tag, (base + 4) % D);
      put_cmpl((base + 2) % D, 32'hC3, 0); tick();
      put_cmpl((base + 3) % D, 32'hD4, 0); tick();
      repeat (5) tick();

      // precise fault
      b2 = (m_head + m_cnt) % D;
      put_alloc(0, 20); tick();
      put_alloc(1, 21); tick();
      put_cmpl((b2 + 1) % D, 32'h5, 0); tick();
      put_cmpl(b2, 32'hEE, 1); tick();
      chk("R9 fault raised", exc_raise, 1);
      chk("R9 fault tag", exc_tag, b2);
      chk("R9 no register write", reg_wr_en, 0);
      tick();
      chk("R9 buffer emptied", alloc_tag, (b2 + 1) % D);
      look((b2 + 1) % D, b2);
      chk("R9 younger discarded", src_ready[0], 0);

      // random mix
      for (int c = 0; c < 4000; c++) begin
         random_stim(c);
         tick();
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule